// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits on the write side of a NOR-flash-style bus and watches every write cycle (address, data byte, write strobe). It recognizes the two six-cycle erase commands: a whole-device erase and a single-sector erase. When either command completes, it sends a one-cycle start pulse to a separate erase engine. For a sector erase it also presents the index of the targeted sector.

After a start, the block holds a busy flag on its own until the engine reports completion. Then it drops busy, clears the latched sector index and accepts new commands. While a whole-device erase runs, every write is dropped. While a sector erase runs, the only write that has any effect is the suspend code, which is forwarded to the engine as a one-cycle request.

Any cycle that breaks a sequence sends the decoder back to array-read mode. A hardware reset clears everything at once.

Top module: `ecd_erase_decoder`

## Requirements
- R1: After reset, busy, both start pulses and the suspend request are low, and the sector index is zero.
- R2: The whole-device erase is recognized after six accepted writes, in this order: (low 11 address bits 0x555, data 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x10). On the clock after the sixth write, the device-erase start is high for exactly one cycle and busy goes high.
- R3: The sector erase uses the same first five writes, followed by a sixth write with data 0x30 at any address. On the clock after the sixth write, the sector start pulses for one cycle, busy goes high, and the sector index shows address bits [20:16] of that sixth write. The index holds that value for the whole erase.
- R4: A write whose address or data does not match its position in the sequence returns the decoder to idle without starting anything. That write is not reused as a first unlock. Only address bits [10:0] take part in the command match.
- R5: Data 0xF0 written at idle leaves the decoder idle. Written mid-sequence, it aborts the partial sequence.
- R6: While a whole-device erase is busy, every write is ignored: no start, no suspend request, and the sector index does not change.
- R7: While a sector erase is busy, a write with data 0xB0 at any address raises the suspend request for one cycle, one clock later. All other writes are ignored.
- R8: Busy stays high until the engine's done input is seen high. On the following clock, busy falls and the sector index returns to zero, and a new full sequence is accepted after that.
- R9: Asserting the active-low reset clears busy and the outputs immediately, without a clock edge, and discards any partial sequence.
- R10: Bus values are used only in cycles with the write strobe high. Idle cycles with any address or data between the writes of a sequence do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 21 | Write address |
| wr_data | input | 8 | Write data byte |
| eng_done | input | 1 | Erase engine reports completion |
| start_chip | output | 1 | One-cycle whole-device erase start |
| start_sector | output | 1 | One-cycle sector erase start |
| susp_req | output | 1 | One-cycle suspend request to the engine |
| sect_idx | output | 5 | Sector index latched for a sector erase |
| busy | output | 1 | Erase in progress |

## Verification
Clean six-write sequences for both commands check that the two final codes are told apart and that the sector index comes from the sixth write's upper bits. Directed sequences then break the command at each of the six positions and keep feeding the remaining cycles. This shows that a broken sequence cannot complete later, even where a leftover write looks like a first unlock. Writes during each kind of erase, including complete command sequences and the suspend code, tell the ignore-all behaviour of a device erase apart from the suspend path of a sector erase. Random runs mix correct and corrupted cycles, random upper address bits and idle gaps. These are compared cycle by cycle against a step model in the bench.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] D_KEY_A  = 8'hAA;
  localparam logic [7:0] D_KEY_B  = 8'h55;
  localparam logic [7:0] D_SETUP  = 8'h80;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_SUSP   = 8'hB0;

  // Position reached in the six-write sequence.
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_SETUP, ST_K3, ST_K4
  } seq_st_t;

  // Meaning of one write at a given position.
  typedef enum logic [1:0] {
    HIT_NONE, HIT_STEP, HIT_CHIP, HIT_SECT
  } hit_t;

  function automatic hit_t classify(seq_st_t st, logic [CMD_AW-1:0] a,
                                    logic [7:0] d);
    hit_t h;
    h = HIT_NONE;
    case (st)
      ST_IDLE, ST_SETUP: if (a == ADR_KEY_A && d == D_KEY_A) h = HIT_STEP;
      ST_K1, ST_K3:      if (a == ADR_KEY_B && d == D_KEY_B) h = HIT_STEP;
      ST_K2:             if (a == ADR_KEY_A && d == D_SETUP) h = HIT_STEP;
      ST_K4: begin
        if (a == ADR_KEY_A && d == D_CHIP) h = HIT_CHIP;
        else if (d == D_SECT)              h = HIT_SECT;
      end
      default: h = HIT_NONE;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/ecd_seq.sv
module ecd_seq
  import ecd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              hold,
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [7:0]        data,
  output logic              hit_chip,
  output logic              hit_sect
);

  seq_st_t state_q;
  hit_t    hit;
  logic    take;

  assign hit      = classify(state_q, addr_lo, data);
  assign take     = wr_en && !hold;
  assign hit_chip = take && (hit == HIT_CHIP);
  assign hit_sect = take && (hit == HIT_SECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (take) begin
      if (hit == HIT_STEP) state_q <= seq_st_t'(state_q + 3'd1);
      else                 state_q <= ST_IDLE;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> state_q == ST_IDLE); // R6
  AST_BAD_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit == HIT_NONE) |=> state_q == ST_IDLE); // R4
  AST_NO_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q)); // R10

endmodule

// File: rtl/ecd_ctrl.sv
module ecd_ctrl
  import ecd_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_chip,
  input  logic              hit_sect,
  input  logic [SECT_W-1:0] sect_in,
  input  logic              wr_en,
  input  logic [7:0]        data,
  input  logic              eng_done,
  output logic              busy,
  output logic              start_chip,
  output logic              start_sect,
  output logic              susp_req,
  output logic [SECT_W-1:0] sect_idx
);

  logic chip_mode;
  logic susp_hit;

  assign susp_hit = busy && !chip_mode && !eng_done && wr_en && (data == D_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      chip_mode  <= 1'b0;
      start_chip <= 1'b0;
      start_sect <= 1'b0;
      susp_req   <= 1'b0;
      sect_idx   <= '0;
    end else begin
      start_chip <= 1'b0;
      start_sect <= 1'b0;
      susp_req   <= susp_hit;
      if (!busy) begin
        if (hit_chip) begin
          busy       <= 1'b1;
          chip_mode  <= 1'b1;
          start_chip <= 1'b1;
        end else if (hit_sect) begin
          busy       <= 1'b1;
          chip_mode  <= 1'b0;
          start_sect <= 1'b1;
          sect_idx   <= sect_in;
        end
      end else if (eng_done) begin
        busy      <= 1'b0;
        chip_mode <= 1'b0;
        sect_idx  <= '0;
      end
    end
  end

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_chip && start_sect)); // R2
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_chip || start_sect) |-> busy && !$past(busy)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> (!busy && sect_idx == '0)); // R8
  AST_SUSP_SECTOR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> (busy && !chip_mode)); // R7
  AST_CHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chip_mode) |=> !susp_req && !start_chip && !start_sect); // R6
  AST_INDEX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sect_idx)); // R6

endmodule

// File: rtl/ecd_erase_decoder.sv
module ecd_erase_decoder
  import ecd_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int SECT_SHIFT = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic                         eng_done,
  output logic                         start_chip,
  output logic                         start_sector,
  output logic                         susp_req,
  output logic [ADDR_W-SECT_SHIFT-1:0] sect_idx,
  output logic                         busy
);

  localparam int SECT_W = ADDR_W - SECT_SHIFT;

  logic hit_chip;
  logic hit_sect;

  ecd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .hold     (busy),
    .addr_lo  (wr_addr[CMD_AW-1:0]),
    .data     (wr_data),
    .hit_chip (hit_chip),
    .hit_sect (hit_sect)
  );

  ecd_ctrl #(.SECT_W(SECT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_chip   (hit_chip),
    .hit_sect   (hit_sect),
    .sect_in    (wr_addr[ADDR_W-1:SECT_SHIFT]),
    .wr_en      (wr_en),
    .data       (wr_data),
    .eng_done   (eng_done),
    .busy       (busy),
    .start_chip (start_chip),
    .start_sect (start_sector),
    .susp_req   (susp_req),
    .sect_idx   (sect_idx)
  );

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !(start_chip || start_sector)); // R6

endmodule

// File: tb/ecd_erase_decoder_test.sv
module ecd_erase_decoder_test;

  localparam int AW = 21;
  localparam int SS = 16;
  localparam int SW = AW - SS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          eng_done = 1'b0;
  logic          start_chip, start_sector, susp_req, busy;
  logic [SW-1:0] sect_idx;

  int checks = 0;
  int errors = 0;

  int          m_step = 0;
  bit          m_busy = 0;
  bit          m_chip = 0;
  logic [SW-1:0] m_sect = '0;

  always #5 clk = ~clk;

  ecd_erase_decoder #(.ADDR_W(AW), .SECT_SHIFT(SS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_done(eng_done), .start_chip(start_chip),
    .start_sector(start_sector), .susp_req(susp_req), .sect_idx(sect_idx),
    .busy(busy)
  );

  // 0 = breaks sequence, 1 = advances, 2 = device erase, 3 = sector erase
  function automatic int bench_kind(int step, logic [AW-1:0] a, logic [7:0] d);
    logic [10:0] lo;
    lo = a[10:0];
    if (step == 0 || step == 3) return (lo == 11'h555 && d == 8'hAA) ? 1 : 0;
    if (step == 1 || step == 4) return (lo == 11'h2AA && d == 8'h55) ? 1 : 0;
    if (step == 2) return (lo == 11'h555 && d == 8'h80) ? 1 : 0;
    if (lo == 11'h555 && d == 8'h10) return 2;
    if (d == 8'h30) return 3;
    return 0;
  endfunction

  function automatic logic [AW-1:0] with_lo(logic [10:0] lo);
    logic [AW-1:0] a;
    a = AW'($urandom);
    a[10:0] = lo;
    return a;
  endfunction

  function automatic logic [10:0] step_addr(int step);
    return (step == 1 || step == 4) ? 11'h2AA : 11'h555;
  endfunction

  function automatic logic [7:0] step_data(int step, bit chip);
    case (step)
      0, 3:    return 8'hAA;
      1, 4:    return 8'h55;
      2:       return 8'h80;
      default: return chip ? 8'h10 : 8'h30;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag, bit ec, bit es, bit esu);
    chk({tag, " start_chip"}, int'(start_chip), int'(ec));
    chk({tag, " start_sector"}, int'(start_sector), int'(es));
    chk({tag, " susp_req"}, int'(susp_req), int'(esu));
    chk({tag, " busy"}, int'(busy), int'(m_busy));
    chk({tag, " sect_idx"}, int'(sect_idx), int'(m_sect));
  endtask

  task automatic write_cyc(logic [AW-1:0] a, logic [7:0] d, string tag);
    bit ec, es, esu;
    int k;
    ec = 0; es = 0; esu = 0;
    if (m_busy) begin
      if (!m_chip && d == 8'hB0) esu = 1;
    end else begin
      k = bench_kind(m_step, a, d);
      if (k == 1) m_step++;
      else begin
        m_step = 0;
        if (k == 2) begin ec = 1; m_busy = 1; m_chip = 1; end
        if (k == 3) begin es = 1; m_busy = 1; m_chip = 0; m_sect = a[AW-1:SS]; end
      end
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check_outs(tag, ec, es, esu);
  endtask

  task automatic idle_junk(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; wr_addr = AW'($urandom); wr_data = 8'($urandom);
    end
    @(negedge clk);
    check_outs(tag, 0, 0, 0);
  endtask

  task automatic full_seq(bit chip, logic [SW-1:0] sect, string tag);
    logic [AW-1:0] a;
    for (int s = 0; s < 6; s++) begin
      a = with_lo(step_addr(s));
      if (s == 5 && !chip) a[AW-1:SS] = sect;
      write_cyc(a, step_data(s, chip), tag);
    end
  endtask

  task automatic done_pulse(string tag);
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    m_busy = 0; m_chip = 0; m_sect = '0;
    check_outs(tag, 0, 0, 0);
  endtask

  task automatic hw_reset(string tag);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    m_busy = 0; m_chip = 0; m_sect = '0; m_step = 0;
    check_outs(tag, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check_outs("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 after release", 0, 0, 0);

    // Device erase, then everything during it is dropped.
    full_seq(1'b1, '0, "R2 device erase");
    @(negedge clk);
    check_outs("R2 pulse ends", 0, 0, 0);
    write_cyc(with_lo(11'h123), 8'hB0, "R6 suspend dropped");
    full_seq(1'b0, 5'd9, "R6 sector cmd dropped");
    full_seq(1'b1, '0, "R6 device cmd dropped");
    idle_junk(4, "R8 busy holds");
    done_pulse("R8 done releases");

    // Sector erase with suspend.
    full_seq(1'b0, 5'd22, "R3 sector erase");
    write_cyc(with_lo(11'h555), 8'hAA, "R7 other write ignored");
    write_cyc(with_lo(11'h7FF), 8'hB0, "R7 suspend");
    @(negedge clk);
    check_outs("R7 suspend one cycle", 0, 0, 0);
    write_cyc(with_lo(11'h555), 8'h10, "R7 device code ignored");
    done_pulse("R8 sector done");
    full_seq(1'b0, 5'd31, "R8 new command after done");
    done_pulse("R8 done again");

    // Break at each position, then feed the rest.
    for (int bad = 0; bad < 6; bad++) begin
      for (int s = 0; s < 6; s++) begin
        if (s == bad) write_cyc(with_lo(step_addr(s) ^ 11'h004), step_data(s, 1'b1), "R4 bad address");
        else write_cyc(with_lo(step_addr(s)), step_data(s, 1'b1), "R4 tail");
      end
      if (m_busy) done_pulse("R4 unexpected");
      for (int s = 0; s < 6; s++) begin
        if (s == bad) write_cyc(with_lo(step_addr(s)), step_data(s, 1'b0) ^ 8'h01, "R4 bad data");
        else write_cyc(with_lo(step_addr(s)), step_data(s, 1'b0), "R4 tail");
      end
      if (m_busy) done_pulse("R4 unexpected");
    end

    // Read-reset code.
    write_cyc(with_lo(11'h555), 8'hF0, "R5 idle reset code");
    for (int s = 0; s < 3; s++) write_cyc(with_lo(step_addr(s)), step_data(s, 1'b1), "R5 prefix");
    write_cyc(with_lo(11'h000), 8'hF0, "R5 abort");
    for (int s = 3; s < 6; s++) write_cyc(with_lo(step_addr(s)), step_data(s, 1'b1), "R5 tail");
    full_seq(1'b1, '0, "R5 clean after abort");
    done_pulse("R5 done");

    // Idle gaps with junk on the bus.
    for (int s = 0; s < 6; s++) begin
      write_cyc(with_lo(step_addr(s)), step_data(s, 1'b0), "R10 gapped");
      idle_junk(2, "R10 gap");
    end
    done_pulse("R10 done");

    // Hardware reset mid-erase and mid-sequence.
    full_seq(1'b0, 5'd5, "R9 start");
    hw_reset("R9 reset during erase");
    for (int s = 0; s < 3; s++) write_cyc(with_lo(step_addr(s)), step_data(s, 1'b1), "R9 prefix");
    hw_reset("R9 reset mid sequence");
    for (int s = 3; s < 6; s++) write_cyc(with_lo(step_addr(s)), step_data(s, 1'b1), "R9 tail");

    // Random mix of correct and corrupted cycles.
    for (int t = 0; t < 300; t++) begin
      bit chip;
      chip = $urandom_range(0, 1) == 1;
      for (int s = 0; s < 6; s++) begin
        logic [AW-1:0] a;
        logic [7:0] d;
        a = with_lo(step_addr(s));
        d = step_data(s, chip);
        if ($urandom_range(0, 19) == 0) a[$urandom_range(0, 10)] ^= 1'b1;
        if ($urandom_range(0, 19) == 0) d[$urandom_range(0, 7)] ^= 1'b1;
        write_cyc(a, d, "R4 random");
        if ($urandom_range(0, 3) == 0) idle_junk(1, "R10 random gap");
      end
      if (m_busy) begin
        for (int j = 0; j < int'($urandom_range(0, 3)); j++)
          write_cyc(AW'($urandom), ($urandom_range(0, 1) == 1) ? 8'hB0 : 8'($urandom), "R6 random busy write");
        done_pulse("R8 random done");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule